// File: doc/BRIEF.md
# Register-Fed CRC-16 Engine

This block computes a 16-bit cyclic redundancy check over a stream of bytes that software pushes in through a small register bus, one byte per write. It keeps a count of the bytes taken in since it was last restarted and shows the running check value at all times, so a driver can confirm the engine with a fixed known-answer vector before using it. It is also the CRC source for a fast infrared link.

The bus is word addressed with two address bits. Word 0 is the control/count register: a write with bit 15 set restarts the engine, and a read returns the input count in bits 11:0. Word 1 is the data port. Word 2 holds the inverted CRC state and cannot be written. Word 3 reads as zero. Reads are combinational. Each write takes effect at the clock edge on which `busWrite` is high, so the next read already shows the result.

Top module: `crc_reg_engine`

## Requirements
- R1: After `rstN` is released, the count in word 0 bits 11:0 is 0 and word 2 reads 0x0000 (state 0xFFFF, inverted on output).
- R2: A write to word 0 with bit 15 = 1 returns the count to 0 and the CRC state to its start value, so word 2 reads 0x0000 on the next read.
- R3: A write to word 0 with bit 15 = 0 changes neither the count nor word 2.
- R4: Each write to word 1 raises the count by one. Word 0 bits 15:12 always read 0.
- R5: A write to word 1 folds bits 7:0 into the CRC least-significant bit first, using polynomial x^16+x^12+x^5+1 in reflected form (0x8408), start value 0xFFFF and output inversion (word 2 = state XOR 0xFFFF).
- R6: Bits 15:8 of a word-1 write have no effect on word 2.
- R7: After a restart, writing 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4 and word 2 = 0x51DF.
- R8: The count holds at 0xFFF instead of wrapping.
- R9: Word 2 is read-only: a write to it changes neither the count nor word 2. Word 3 reads as 0.
- R10: The effect of any write is visible on a read in the cycle after the write edge, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Word address: 0 control/count, 1 data, 2 result, 3 unused |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for `busAddr` |

## Verification
The hardest state to reach from the ports is the saturated count: the bench has to make more than four thousand data writes without a restart and then read the count as it passes 0xFFE, 0xFFF and beyond. It also sweeps all 256 byte values as single-byte messages after a restart. It runs multi-byte sequences with random upper bits and compares each against a bit-serial reference computed inside the bench.

// File: rtl/crc_pkg.sv
`timescale 1ns/1ps
package crc_pkg;
  localparam int ADDR_W = 2;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int CNT_W  = 12;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OUT  = 2'd2;

  localparam int RESTART_BIT = 15;

  typedef struct packed {
    logic              restart;
    logic              feed;
    logic [BYTE_W-1:0] dataByte;
  } crcStrobe_t;

  // Fold one byte into a reflected CRC, least significant bit first.
  function automatic logic [CRC_W-1:0] foldByte(
    input logic [CRC_W-1:0]  state,
    input logic [BYTE_W-1:0] din,
    input logic [CRC_W-1:0]  polyRef
  );
    logic [CRC_W-1:0] s;
    s = state;
    for (int i = 0; i < BYTE_W; i++) begin
      if (s[0] ^ din[i]) s = (s >> 1) ^ polyRef;
      else               s = s >> 1;
    end
    return s;
  endfunction
endpackage

// File: rtl/crc_ctrl.sv
`timescale 1ns/1ps
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int CNT_WIDTH = CNT_W
) (
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrite,
  input  logic [BUS_W-1:0]     busWdata,
  input  logic [CNT_WIDTH-1:0] cntVal,
  input  logic [CRC_W-1:0]     crcVal,
  output crcStrobe_t           strobe,
  output logic [BUS_W-1:0]     busRdata
);
  always_comb begin
    strobe.restart  = busWrite && (busAddr == ADDR_CTRL) && busWdata[RESTART_BIT];
    strobe.feed     = busWrite && (busAddr == ADDR_DATA);
    strobe.dataByte = busWdata[BYTE_W-1:0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL: busRdata[CNT_WIDTH-1:0] = cntVal;
      ADDR_OUT:  busRdata = crcVal;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_datapath.sv
`timescale 1ns/1ps
module crc_datapath
  import crc_pkg::*;
#(
  parameter int               CNT_WIDTH = CNT_W,
  parameter logic [CRC_W-1:0] POLY_REF  = 16'h8408,
  parameter logic [CRC_W-1:0] INIT_VAL  = 16'hFFFF,
  parameter logic [CRC_W-1:0] OUT_XOR   = 16'hFFFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  crcStrobe_t           strobe,
  output logic [CNT_WIDTH-1:0] cntVal,
  output logic [CRC_W-1:0]     crcVal
);
  localparam logic [CNT_WIDTH-1:0] CNT_MAX = '1;

  logic [CRC_W-1:0]     stateQ;
  logic [CNT_WIDTH-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= INIT_VAL;
      cntQ   <= '0;
    end else if (strobe.restart) begin
      stateQ <= INIT_VAL;
      cntQ   <= '0;
    end else if (strobe.feed) begin
      stateQ <= foldByte(stateQ, strobe.dataByte, POLY_REF);
      if (cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
    end
  end

  assign cntVal = cntQ;
  assign crcVal = stateQ ^ OUT_XOR;
endmodule

// File: rtl/crc_reg_engine.sv
`timescale 1ns/1ps
module crc_reg_engine
  import crc_pkg::*;
#(
  parameter int               CNT_WIDTH = CNT_W,
  parameter logic [CRC_W-1:0] POLY_REF  = 16'h8408,
  parameter logic [CRC_W-1:0] INIT_VAL  = 16'hFFFF,
  parameter logic [CRC_W-1:0] OUT_XOR   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrite,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata
);
  crcStrobe_t           strobe;
  logic [CNT_WIDTH-1:0] cntVal;
  logic [CRC_W-1:0]     crcVal;

  crc_ctrl #(.CNT_WIDTH(CNT_WIDTH)) u_ctrl (
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .cntVal   (cntVal),
    .crcVal   (crcVal),
    .strobe   (strobe),
    .busRdata (busRdata)
  );

  crc_datapath #(
    .CNT_WIDTH (CNT_WIDTH),
    .POLY_REF  (POLY_REF),
    .INIT_VAL  (INIT_VAL),
    .OUT_XOR   (OUT_XOR)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cntVal (cntVal),
    .crcVal (crcVal)
  );
endmodule

// File: rtl/crc_reg_engine_chk.sv
`timescale 1ns/1ps
module crc_reg_engine_chk #(
  parameter int CNT_WIDTH = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           busAddr,
  input logic                 busWrite,
  input logic [15:0]          busWdata,
  input logic [CNT_WIDTH-1:0] cntVal,
  input logic [15:0]          crcVal
);
  localparam logic [CNT_WIDTH-1:0] CNT_MAX = '1;

  // R2: restart clears count and result
  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 2'd0 && busWdata[15]) |=> (cntVal == '0 && crcVal == 16'h0000));

  // R3: control write without restart bit holds state
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 2'd0 && !busWdata[15]) |=> ($stable(cntVal) && $stable(crcVal)));

  // R4: data write advances the count below the limit
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 2'd1 && cntVal != CNT_MAX) |=> (cntVal == $past(cntVal) + 1'b1));

  // R8: count holds at its limit
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 2'd1 && cntVal == CNT_MAX) |=> (cntVal == CNT_MAX));

  // R9: writes to the result word or the unused word change nothing
  p_read_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr[1]) |=> ($stable(cntVal) && $stable(crcVal)));

  // R10: idle bus keeps state
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite) |=> ($stable(cntVal) && $stable(crcVal)));
endmodule

bind crc_reg_engine crc_reg_engine_chk #(.CNT_WIDTH(CNT_WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrite (busWrite),
  .busWdata (busWdata),
  .cntVal   (cntVal),
  .crcVal   (crcVal)
);

// File: tb/crc_reg_engine_test.sv
`timescale 1ns/1ps
module crc_reg_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  crc_reg_engine uut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .busRdata (busRdata)
  );

  always #4 clk = ~clk;

  // Reference: reflected x^16+x^12+x^5+1, LSB first
  function automatic logic [15:0] refStep(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] r;
    r = s ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    logic [15:0] model;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(2'd0, rd); check("R1 count", rd, 16'h0000);
    busRd(2'd2, rd); check("R1 result", rd, 16'h0000);
    busRd(2'd3, rd); check("R9 unused word", rd, 16'h0000);

    // R7 known answer, with R10 read right after each write
    busWr(2'd0, 16'h8000);
    model = 16'hFFFF;
    foreach (model[i]) ; // no-op keeps model intact
    begin
      logic [7:0] kv [4] = '{8'hCC, 8'hF5, 8'hF1, 8'hA7};
      for (int i = 0; i < 4; i++) begin
        busWr(2'd1, {8'h00, kv[i]});
        model = refStep(model, kv[i]);
        busRd(2'd2, rd); check("R10 result after write", rd, model ^ 16'hFFFF);
      end
    end
    busRd(2'd0, rd); check("R7 count", rd, 16'd4);
    busRd(2'd2, rd); check("R7 known answer", rd, 16'h51DF);

    // R3 control write without restart
    busWr(2'd0, 16'h7FFF);
    busRd(2'd0, rd); check("R3 count held", rd, 16'd4);
    busRd(2'd2, rd); check("R3 result held", rd, 16'h51DF);

    // R9 write to result word
    busWr(2'd2, 16'h1234);
    busWr(2'd3, 16'hFFFF);
    busRd(2'd0, rd); check("R9 count held", rd, 16'd4);
    busRd(2'd2, rd); check("R9 result held", rd, 16'h51DF);

    // R2 restart
    busWr(2'd0, 16'h8000);
    busRd(2'd0, rd); check("R2 count cleared", rd, 16'h0000);
    busRd(2'd2, rd); check("R2 result cleared", rd, 16'h0000);

    // R5 exhaustive single-byte sweep
    for (int b = 0; b < 256; b++) begin
      busWr(2'd0, 16'h8000);
      busWr(2'd1, 16'(b));
      busRd(2'd2, rd);
      check("R5 single byte", rd, refStep(16'hFFFF, 8'(b)) ^ 16'hFFFF);
    end

    // R6 upper bits ignored, multi-byte sequences
    for (int seq = 0; seq < 8; seq++) begin
      busWr(2'd0, 16'h8000);
      model = 16'hFFFF;
      for (int n = 0; n < 5 + seq; n++) begin
        logic [7:0] lo;
        logic [7:0] hi;
        lo = 8'((seq * 37 + n * 91 + 11) & 8'hFF);
        hi = 8'((seq * 53 + n * 29 + 1) & 8'hFF) | 8'h01;
        busWr(2'd1, {hi, lo});
        model = refStep(model, lo);
      end
      busRd(2'd2, rd); check("R6 upper bits ignored", rd, model ^ 16'hFFFF);
      busRd(2'd0, rd); check("R4 count", rd, 16'(5 + seq));
    end

    // R8 saturation
    busWr(2'd0, 16'h8000);
    for (int n = 1; n <= 4100; n++) begin
      busWr(2'd1, 16'hFF00 | 16'(n & 8'hFF));
      if (n == 4094 || n == 4095 || n == 4096 || n == 4100) begin
        busRd(2'd0, rd);
        check("R8 saturating count", rd, (n >= 4095) ? 16'h0FFF : 16'(n));
      end
    end
    busRd(2'd0, rd); check("R4 upper count bits zero", rd & 16'hF000, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule